// File: doc/BRIEF.md
# Serial Register-Bank Command Port

This block is a three-wire serial slave (clock, data in, data out) that gives a host access to the control registers of a measurement converter. Every transaction opens with an 8-bit command byte. The byte names one of eight registers and the direction of the next access, and it also carries a standby flag and a channel number. These two fields drive the converter directly. After the command, the block shifts in or shifts out as many bits as the chosen register holds. It then falls back to waiting for the next command.

The block holds the register bank at its reset values and latches each new conversion result when the update strobe pulses. It drives an active-low data-ready line. A long run of ones on the data input brings the interface back to the command-waiting state. The serial lines are synchronised into the system clock domain, and the converter-side inputs and outputs are synchronous to that clock.

Top module: `ser_regbank_port`

## Requirements
- R1: After reset, the setup register is 0x01, the clock register is 0x05, the test register is 0x00, every zero-scale register is 0x1F4000 and every full-scale register is 0x5761AB. drdy_o and dout_o are high, stby_o is 0 and chan_o is 0.
- R2: A command byte is sent MSB first. Bit 7 is the start bit and must be 0. Bits 6:4 select the register: 0 command, 1 setup, 2 clock, 3 data, 4 test, 5 none, 6 zero-scale, 7 full-scale. Bit 3 gives the direction (1 = read). Bit 2 is standby and bits 1:0 are the channel. Each command updates stby_o and chan_o. A command that selects register 0 for writing leaves the block waiting for a command.
- R3: While the block waits for a command, a 1 in the start-bit position is skipped. The first 0 begins the byte, and the following seven bits fill bits 6:0.
- R4: An access shifts 8 bits for the command, setup, clock, test and none registers, 16 bits for the data register and 24 bits for the calibration registers. After the last bit, the block waits for a command again.
- R5: din_i is taken on the rising edge of sclk_i. dout_o changes only after falling edges of sclk_i, MSB first, and is 1 outside a read. A read of setup, clock, test or a calibration register returns its stored value. A read of register 5 returns 0. A read of the command register returns {drdy, bits 6:0 of that command}.
- R6: A write to the data register shifts all 16 bits but does not change the stored result.
- R7: Each channel code 0..2 has its own zero-scale/full-scale pair, and code 3 uses pair 0. cal_zero_o and cal_full_o show the pair of the current channel.
- R8: A calibration register changes only when all 24 of its bits have been shifted in. A write cut short leaves it unchanged.
- R9: ESC_ONES consecutive ones on din_i (default 32) return the interface to the command-waiting state and discard any partial write.
- R10: An upd_i pulse latches conv_data_i and drives drdy_o low. The end of a data-register read drives drdy_o high. The same result can be read again while drdy_o stays high.
- R11: When upd_i falls in the same cycle as the end of a data-register read, drdy_o stays low. That read returns the old result and the next read returns the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, idles high |
| din_i | input | 1 | Serial data from host |
| dout_o | output | 1 | Serial data to host |
| upd_i | input | 1 | One-cycle strobe marking a new conversion result |
| conv_data_i | input | 16 | Conversion result |
| drdy_o | output | 1 | Data ready, active low |
| stby_o | output | 1 | Standby flag from last command |
| chan_o | output | 2 | Channel from last command |
| setup_o | output | 8 | Setup register |
| clkcfg_o | output | 8 | Clock register |
| cal_zero_o | output | 24 | Zero-scale value of the current channel |
| cal_full_o | output | 24 | Full-scale value of the current channel |

## Verification
A new conversion strobe and the last bit of a data-register read can land on the same system clock. One wants drdy_o set and the other wants it cleared. The bench counts the synchroniser stages from its own sclk_i rising edge and pulses upd_i in exactly the cycle where that edge is acted on. It then expects drdy_o to stay low, expects the read in progress to return the old result, and expects the following read to return the new one.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned RES_W  = 16;
  localparam int unsigned CMD_W  = 7;

  typedef enum logic [2:0] {
    SEL_CMD   = 3'd0,
    SEL_SETUP = 3'd1,
    SEL_CLK   = 3'd2,
    SEL_DATA  = 3'd3,
    SEL_TEST  = 3'd4,
    SEL_NONE  = 3'd5,
    SEL_ZERO  = 3'd6,
    SEL_FULL  = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {ST_CMD, ST_WR, ST_RD} frm_st_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic       rd;
    logic       stby;
    logic [1:0] ch;
  } cmd_t;

  function automatic logic [4:0] reg_bits(input reg_sel_e s);
    case (s)
      SEL_DATA:           reg_bits = 5'd16;
      SEL_ZERO, SEL_FULL: reg_bits = 5'd24;
      default:            reg_bits = 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/srb_edge_sync.sv
module srb_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic din_i,
  output logic rise_o,
  output logic fall_o,
  output logic din_o
);
  logic [STAGES:0]   sck_q;
  logic [STAGES-1:0] din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= '1;
      din_q <= '0;
    end else begin
      sck_q <= {sck_q[STAGES-1:0], sclk_i};
      din_q <= {din_q[STAGES-2:0], din_i};
    end
  end

  assign rise_o = sck_q[STAGES-1] & ~sck_q[STAGES];
  assign fall_o = ~sck_q[STAGES-1] & sck_q[STAGES];
  assign din_o  = din_q[STAGES-1];
endmodule

// File: rtl/srb_frame_ctrl.sv
module srb_frame_ctrl
  import srb_pkg::*;
#(
  parameter int unsigned ESC_ONES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              din_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              cmd_we_o,
  output cmd_t              cmd_o,
  output logic              wr_en_o,
  output reg_sel_e          wr_sel_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              rd_data_done_o,
  output logic              dout_o
);
  localparam int unsigned OW = $clog2(ESC_ONES + 1);

  frm_st_e           st_q;
  logic              cmd_act_q;
  logic [4:0]        cnt_q;
  logic [WORD_W-2:0] rx_q;
  logic [WORD_W-1:0] tx_q;
  reg_sel_e          sel_q;
  logic [OW-1:0]     ones_q;
  logic              dout_q;

  cmd_t       cmd_nxt;
  logic [4:0] w_cur;
  logic       last;
  logic       esc;
  logic       cmd_done;

  assign cmd_nxt  = cmd_t'({rx_q[CMD_W-2:0], din_i});
  assign w_cur    = reg_bits(sel_q);
  assign last     = (cnt_q == 5'(w_cur - 5'd1));
  assign esc      = rise_i && din_i && (ones_q == OW'(ESC_ONES - 1));
  assign cmd_done = rise_i && !esc && (st_q == ST_CMD) && cmd_act_q && (cnt_q == 5'd6);

  assign cmd_we_o       = cmd_done;
  assign cmd_o          = cmd_nxt;
  assign wr_en_o        = rise_i && !esc && (st_q == ST_WR) && last;
  assign wr_sel_o       = sel_q;
  assign wr_data_o      = {rx_q, din_i};
  assign rd_data_done_o = rise_i && !esc && (st_q == ST_RD) && last && (sel_q == SEL_DATA);
  assign dout_o         = dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_CMD;
      cmd_act_q <= 1'b0;
      cnt_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      sel_q     <= SEL_CMD;
      ones_q    <= '0;
      dout_q    <= 1'b1;
    end else if (esc) begin
      st_q      <= ST_CMD;
      cmd_act_q <= 1'b0;
      cnt_q     <= '0;
      ones_q    <= '0;
    end else if (rise_i) begin
      ones_q <= din_i ? OW'(ones_q + 1'b1) : '0;
      unique case (st_q)
        ST_CMD: begin
          if (!cmd_act_q) begin
            // idle on the start bit until a 0 arrives
            if (!din_i) begin
              cmd_act_q <= 1'b1;
              cnt_q     <= '0;
            end
          end else begin
            rx_q <= {rx_q[WORD_W-3:0], din_i};
            if (cnt_q == 5'd6) begin
              cmd_act_q <= 1'b0;
              cnt_q     <= '0;
              sel_q     <= cmd_nxt.sel;
              if (cmd_nxt.rd) begin
                st_q <= ST_RD;
                tx_q <= rd_word_i << (5'd24 - reg_bits(cmd_nxt.sel));
              end else if (cmd_nxt.sel != SEL_CMD) begin
                st_q <= ST_WR;
              end
            end else begin
              cnt_q <= cnt_q + 5'd1;
            end
          end
        end
        ST_WR: begin
          rx_q <= {rx_q[WORD_W-3:0], din_i};
          if (last) begin
            st_q  <= ST_CMD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 5'd1;
          end
        end
        ST_RD: begin
          if (last) begin
            st_q  <= ST_CMD;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 5'd1;
          end
        end
        default: st_q <= ST_CMD;
      endcase
    end else if (fall_i) begin
      if (st_q == ST_RD) begin
        dout_q <= tx_q[WORD_W-1];
        tx_q   <= {tx_q[WORD_W-2:0], 1'b0};
      end else begin
        dout_q <= 1'b1;
      end
    end
  end

  AST_DOUT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_q) |-> $past(fall_i)); // R5
  AST_BITS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_CMD) |-> (cnt_q < reg_bits(sel_q))); // R4
  AST_ESC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> (st_q == ST_CMD) && !cmd_act_q); // R9
endmodule

// File: rtl/srb_reg_bank.sv
module srb_reg_bank
  import srb_pkg::*;
#(
  parameter int unsigned NUM_CH     = 3,
  parameter logic [7:0]  SETUP_RST  = 8'h01,
  parameter logic [7:0]  CLK_RST    = 8'h05,
  parameter logic [7:0]  TEST_RST   = 8'h00,
  parameter logic [23:0] ZERO_RST   = 24'h1F4000,
  parameter logic [23:0] FULL_RST   = 24'h5761AB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  cmd_t              cmd_i,
  input  logic              wr_en_i,
  input  reg_sel_e          wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_data_done_i,
  input  logic              upd_i,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic              drdy_o,
  output logic              stby_o,
  output logic [1:0]        chan_o,
  output logic [7:0]        setup_o,
  output logic [7:0]        clkcfg_o,
  output logic [WORD_W-1:0] cal_zero_o,
  output logic [WORD_W-1:0] cal_full_o
);
  localparam int unsigned PW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [7:0]        setup_q, clk_q, test_q;
  logic [RES_W-1:0]  data_q;
  logic              stby_q, drdy_q;
  logic [1:0]        ch_q;
  logic [WORD_W-1:0] zs_q [NUM_CH];
  logic [WORD_W-1:0] fs_q [NUM_CH];

  function automatic logic [PW-1:0] pidx(input logic [1:0] ch);
    pidx = (32'(ch) < NUM_CH) ? PW'(ch) : '0;
  endfunction

  logic [PW-1:0] wr_pidx, rd_pidx, cur_pidx;
  assign wr_pidx  = pidx(ch_q);
  assign rd_pidx  = pidx(cmd_i.ch);
  assign cur_pidx = pidx(ch_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_q <= SETUP_RST;
      clk_q   <= CLK_RST;
      test_q  <= TEST_RST;
      data_q  <= '0;
      stby_q  <= 1'b0;
      ch_q    <= '0;
      drdy_q  <= 1'b1;
      for (int i = 0; i < NUM_CH; i++) begin
        zs_q[i] <= ZERO_RST;
        fs_q[i] <= FULL_RST;
      end
    end else begin
      if (cmd_we_i) begin
        stby_q <= cmd_i.stby;
        ch_q   <= cmd_i.ch;
      end
      if (upd_i) data_q <= conv_data_i;
      // a fresh result outranks the read that would clear the flag
      if (upd_i)               drdy_q <= 1'b0;
      else if (rd_data_done_i) drdy_q <= 1'b1;
      if (wr_en_i) begin
        unique case (wr_sel_i)
          SEL_SETUP: setup_q <= wr_data_i[7:0];
          SEL_CLK:   clk_q   <= wr_data_i[7:0];
          SEL_TEST:  test_q  <= wr_data_i[7:0];
          SEL_ZERO: begin
            for (int i = 0; i < NUM_CH; i++)
              if (wr_pidx == PW'(i)) zs_q[i] <= wr_data_i;
          end
          SEL_FULL: begin
            for (int i = 0; i < NUM_CH; i++)
              if (wr_pidx == PW'(i)) fs_q[i] <= wr_data_i;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    unique case (cmd_i.sel)
      SEL_CMD:   rd_word_o = {16'd0, drdy_q, cmd_i};
      SEL_SETUP: rd_word_o = {16'd0, setup_q};
      SEL_CLK:   rd_word_o = {16'd0, clk_q};
      SEL_DATA:  rd_word_o = {8'd0, data_q};
      SEL_TEST:  rd_word_o = {16'd0, test_q};
      SEL_ZERO:  rd_word_o = zs_q[rd_pidx];
      SEL_FULL:  rd_word_o = fs_q[rd_pidx];
      default:   rd_word_o = '0;
    endcase
  end

  assign drdy_o     = drdy_q;
  assign stby_o     = stby_q;
  assign chan_o     = ch_q;
  assign setup_o    = setup_q;
  assign clkcfg_o   = clk_q;
  assign cal_zero_o = zs_q[cur_pidx];
  assign cal_full_o = fs_q[cur_pidx];

  AST_DRDY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !drdy_o); // R10
  AST_DRDY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |-> $past(rd_data_done_i)); // R10
  AST_UPD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && rd_data_done_i) |=> !drdy_o); // R11
  AST_DATA_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_DATA && !upd_i) |=> $stable(data_q)); // R6

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cal_chk
    AST_CAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == SEL_ZERO && wr_pidx == PW'(g)) |=> $stable(zs_q[g])); // R8
    AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == SEL_FULL && wr_pidx == PW'(g)) |=> $stable(fs_q[g])); // R8
  end
endmodule

// File: rtl/ser_regbank_port.sv
module ser_regbank_port
  import srb_pkg::*;
#(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ESC_ONES    = 32,
  parameter logic [7:0]  SETUP_RST   = 8'h01,
  parameter logic [7:0]  CLK_RST     = 8'h05,
  parameter logic [7:0]  TEST_RST    = 8'h00,
  parameter logic [23:0] ZERO_RST    = 24'h1F4000,
  parameter logic [23:0] FULL_RST    = 24'h5761AB
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        din_i,
  output logic        dout_o,
  input  logic        upd_i,
  input  logic [15:0] conv_data_i,
  output logic        drdy_o,
  output logic        stby_o,
  output logic [1:0]  chan_o,
  output logic [7:0]  setup_o,
  output logic [7:0]  clkcfg_o,
  output logic [23:0] cal_zero_o,
  output logic [23:0] cal_full_o
);
  logic              rise, fall, din_s;
  logic              cmd_we, wr_en, rd_data_done;
  cmd_t              cmd;
  reg_sel_e          wr_sel;
  logic [WORD_W-1:0] wr_data, rd_word;

  srb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .din_i  (din_i),
    .rise_o (rise),
    .fall_o (fall),
    .din_o  (din_s)
  );

  srb_frame_ctrl #(.ESC_ONES(ESC_ONES)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rise_i         (rise),
    .fall_i         (fall),
    .din_i          (din_s),
    .rd_word_i      (rd_word),
    .cmd_we_o       (cmd_we),
    .cmd_o          (cmd),
    .wr_en_o        (wr_en),
    .wr_sel_o       (wr_sel),
    .wr_data_o      (wr_data),
    .rd_data_done_o (rd_data_done),
    .dout_o         (dout_o)
  );

  srb_reg_bank #(
    .NUM_CH    (NUM_CH),
    .SETUP_RST (SETUP_RST),
    .CLK_RST   (CLK_RST),
    .TEST_RST  (TEST_RST),
    .ZERO_RST  (ZERO_RST),
    .FULL_RST  (FULL_RST)
  ) u_bank (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cmd_we_i       (cmd_we),
    .cmd_i          (cmd),
    .wr_en_i        (wr_en),
    .wr_sel_i       (wr_sel),
    .wr_data_i      (wr_data),
    .rd_data_done_i (rd_data_done),
    .upd_i          (upd_i),
    .conv_data_i    (conv_data_i),
    .rd_word_o      (rd_word),
    .drdy_o         (drdy_o),
    .stby_o         (stby_o),
    .chan_o         (chan_o),
    .setup_o        (setup_o),
    .clkcfg_o       (clkcfg_o),
    .cal_zero_o     (cal_zero_o),
    .cal_full_o     (cal_full_o)
  );
endmodule

// File: tb/ser_regbank_port_tb.sv
`timescale 1ns/1ps
module ser_regbank_port_tb;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sclk = 1'b1;
  logic        din = 1'b1;
  logic        upd = 1'b0;
  logic [15:0] conv = '0;
  logic        dout, drdy, stby;
  logic [1:0]  chan;
  logic [7:0]  setup, clkcfg;
  logic [23:0] czero, cfull;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] rd_got;
  event        rd_evt;

  always #2.5 clk = ~clk;

  ser_regbank_port #(.ESC_ONES(20)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .din_i(din), .dout_o(dout),
    .upd_i(upd), .conv_data_i(conv), .drdy_o(drdy), .stby_o(stby), .chan_o(chan),
    .setup_o(setup), .clkcfg_o(clkcfg), .cal_zero_o(czero), .cal_full_o(cfull)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial forever begin
    @(rd_evt);
    chk(tag_q.pop_front(), rd_got, exp_q.pop_front());
  end

  task automatic xfer(input logic v, output logic got, input bit pulse);
    sclk = 1'b0;
    din  = v;
    repeat (H) @(negedge clk);
    got  = dout;
    sclk = 1'b1;
    if (pulse) begin
      repeat (2) @(negedge clk);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      repeat (H - 3) @(negedge clk);
    end else begin
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic send_bits(input logic [23:0] val, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      logic d;
      xfer(val[i], d, 1'b0);
    end
  endtask

  task automatic rd_reg(input logic [7:0] cmd, input int w, input logic [23:0] exp,
                        input string tag, input bit collide);
    logic [23:0] acc;
    acc = '0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send_bits({16'd0, cmd}, 8);
    for (int i = 0; i < w; i++) begin
      logic b;
      xfer(1'b0, b, collide && (i == w - 1));
      acc = {acc[22:0], b};
    end
    rd_got = acc;
    ->rd_evt;
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [23:0] val, input int w);
    send_bits({16'd0, cmd}, 8);
    send_bits(val, w);
  endtask

  task automatic pulse_upd(input logic [15:0] d);
    conv = d;
    upd  = 1'b1;
    @(negedge clk);
    upd  = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 drdy", {23'd0, drdy}, 24'd1);
    chk("R1 dout", {23'd0, dout}, 24'd1);
    chk("R1 stby/chan", {21'd0, stby, chan}, 24'd0);
    chk("R1 setup_o", {16'd0, setup}, 24'h01);
    chk("R1 clkcfg_o", {16'd0, clkcfg}, 24'h05);

    rd_reg(8'h18, 8, 24'h01, "R1 R5 setup read", 0);
    rd_reg(8'h28, 8, 24'h05, "R1 R5 clock read", 0);
    rd_reg(8'h48, 8, 24'h00, "R1 test read", 0);
    rd_reg(8'h68, 24, 24'h1F4000, "R1 R4 zero-scale ch0", 0);
    rd_reg(8'h7A, 24, 24'h5761AB, "R1 R4 full-scale ch2", 0);
    rd_reg(8'h08, 8, 24'h88, "R5 command read", 0);
    rd_reg(8'h58, 8, 24'h00, "R5 none read", 0);

    wr_reg(8'h10, 24'h5A, 8);
    chk("R5 setup_o after write", {16'd0, setup}, 24'h5A);
    rd_reg(8'h18, 8, 24'h5A, "R5 setup readback", 0);
    wr_reg(8'h20, 24'hC3, 8);
    wr_reg(8'h40, 24'h3C, 8);
    chk("R5 clkcfg_o after write", {16'd0, clkcfg}, 24'hC3);
    send_bits(24'h1F, 5);   // leading ones before a command
    rd_reg(8'h48, 8, 24'h3C, "R3 test read after idle ones", 0);

    send_bits(24'h06, 8);   // write-to-command: standby on, channel 2
    chk("R2 stby_o", {23'd0, stby}, 24'd1);
    chk("R2 chan_o", {22'd0, chan}, 24'd2);
    rd_reg(8'h0E, 8, 24'h8E, "R2 command read fields", 0);
    rd_reg(8'h18, 8, 24'h5A, "R2 R4 next command parsed", 0);
    chk("R2 stby_o cleared", {23'd0, stby}, 24'd0);

    wr_reg(8'h61, 24'h123456, 24);
    chk("R7 cal_zero_o ch1", czero, 24'h123456);
    wr_reg(8'h72, 24'hABCDE0, 24);
    rd_reg(8'h68, 24, 24'h1F4000, "R7 zero-scale ch0 untouched", 0);
    rd_reg(8'h69, 24, 24'h123456, "R7 zero-scale ch1", 0);
    rd_reg(8'h7A, 24, 24'hABCDE0, "R7 full-scale ch2", 0);
    rd_reg(8'h79, 24, 24'h5761AB, "R7 full-scale ch1 untouched", 0);
    wr_reg(8'h63, 24'h0F0F0F, 24);
    rd_reg(8'h68, 24, 24'h0F0F0F, "R7 code 3 shares pair 0", 0);
    chk("R7 cal_zero_o ch0", czero, 24'h0F0F0F);

    pulse_upd(16'hBEEF);
    chk("R10 drdy low after update", {23'd0, drdy}, 24'd0);
    rd_reg(8'h38, 16, 24'hBEEF, "R10 data read", 0);
    chk("R10 drdy high after read", {23'd0, drdy}, 24'd1);
    rd_reg(8'h38, 16, 24'hBEEF, "R10 data reread", 0);

    wr_reg(8'h30, 24'h1234, 16);
    rd_reg(8'h18, 8, 24'h5A, "R6 R4 sync after data write", 0);
    rd_reg(8'h38, 16, 24'hBEEF, "R6 data unchanged", 0);

    pulse_upd(16'h1111);
    conv = 16'h2222;
    rd_reg(8'h38, 16, 24'h1111, "R11 read during collision", 1);
    chk("R11 drdy stays low", {23'd0, drdy}, 24'd0);
    rd_reg(8'h38, 16, 24'h2222, "R11 new result", 0);
    chk("R11 drdy high after next read", {23'd0, drdy}, 24'd1);

    wr_reg(8'h61, 24'hFFFFFF, 24);   // 20th one aborts the write
    rd_reg(8'h69, 24, 24'h123456, "R8 R9 aborted cal write", 0);
    send_bits(24'h3, 3);             // partial command, then a long run of ones
    send_bits(24'hFFFFF, 20);
    rd_reg(8'h18, 8, 24'h5A, "R9 resync after ones", 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule